// File: doc/BRIEF.md
# Fetch Address Sequencer with Lookahead

This block produces the address and cycle attributes for each memory cycle of a simple 32-bit processor bus. Each advancing clock edge either moves the address on by one word, keeps it, or loads a branch target. The new address appears on the port together with a read/write flag and a translate flag for the memory management unit. A combinational lookahead hint, `seq_o`, tells the memory system during the current cycle whether the next address will be the same word or the word directly after it. The memory system can use this hint to keep a page open or to skip translation.

The block has no separate clear input. The active-low reset `rst_n_i` is sampled like any other input. While it is low, the sequencer keeps issuing dummy read fetches that step forward one word each cycle and wrap at the top of the address space. On the first advancing edge after the reset is seen high, the sequencer restarts at address zero. The active-low `wait_n_i` input stretches the current cycle by whole clock cycles. The `wide_mode_i` input selects between a 32-bit fetch space and a 26-bit fetch space.

Top module: `fetch_addr_seq`

## Requirements
- R1: At every edge where `wait_n_i` is high and `rst_n_i` is low, the address advances by 4 from its current value, `rw_o` becomes 0 (read) and `trans_o` becomes 1.
- R2: Dummy fetches wrap to zero past the top of the space: 0xFFFFFFFC goes to 0 when `wide_mode_i` is 1, and 0x03FFFFFC goes to 0 when it is 0.
- R3: On the first advancing edge with `rst_n_i` high after an advancing edge with it low, the address becomes 0. This also holds when the low period lasted a single cycle.
- R4: At an edge where `wait_n_i` is 0, `addr_o`, `rw_o` and `trans_o` keep their values, for any number of consecutive cycles. Every other input is ignored at that edge, including `rst_n_i`.
- R5: `seq_o` is 1 in a cycle exactly when the address after the next advancing edge, given the current inputs, equals `addr_o` or equals `addr_o`+4 without crossing the top of the selected space.
- R6: After an advancing edge outside reset, `rw_o` equals the `write_next_i` value sampled at that edge (1 = write, 0 = read).
- R7: After an advancing edge outside reset, `trans_o` is the inverse of the `user_i` value sampled at that edge (0 in user mode).
- R8: With `wide_mode_i` 0, every address produced has bits 31:26 at zero. Increments wrap inside the 26-bit space, and branch targets lose bits 31:26.
- R9: Outside reset, the next address is chosen in priority order: restart to 0, then the branch target when `branch_i` is 1, then the same address when `hold_i` is 1, then the current address plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_n_i | input | 1 | Level-sensitive active-low reset, sampled each cycle |
| wait_n_i | input | 1 | Active-low stall; low freezes the current cycle |
| wide_mode_i | input | 1 | 1 selects the 32-bit fetch space, 0 the 26-bit space |
| branch_i | input | 1 | Load `target_i` as the next address |
| target_i | input | 32 | Branch target address |
| hold_i | input | 1 | Repeat the current address in the next cycle |
| write_next_i | input | 1 | Next cycle is a write |
| user_i | input | 1 | Next cycle runs in user mode |
| addr_o | output | 32 | Address of the current memory cycle |
| rw_o | output | 1 | 1 write, 0 read, for the current cycle |
| trans_o | output | 1 | 0 when the current cycle is a user-mode access |
| seq_o | output | 1 | Next address is the same word or the following word |

## Verification
The assertions are switched off while `rst_n_i` is low, so behaviour during reset is checked only by the bench's model. The lookahead properties assume that the inputs steering the next address stay steady between the cycle in which `seq_o` is read and the advancing edge. The stimulus keeps to this by driving every input once per cycle, just after the clock edge, and never changing it before the following edge. Stalls are made by lowering `wait_n_i` while `branch_i`, `hold_i` and `wide_mode_i` stay fixed. The other inputs are still varied during a stall to show that they are ignored.

// File: rtl/fas_pkg.sv
package fas_pkg;

    // Decision taken for the next advancing edge, highest priority first.
    typedef enum logic [2:0] {
        ACT_DUMMY,
        ACT_RESTART,
        ACT_BRANCH,
        ACT_HOLD,
        ACT_INC
    } fas_act_e;

endpackage

// File: rtl/fas_action_sel.sv
module fas_action_sel
    import fas_pkg::*;
(
    input  logic     rst_n_i,
    input  logic     in_reset_i,
    input  logic     branch_i,
    input  logic     hold_i,
    output fas_act_e act_o
);

    always_comb begin
        if (!rst_n_i) begin
            act_o = ACT_DUMMY;
        end else if (in_reset_i) begin
            act_o = ACT_RESTART;
        end else if (branch_i) begin
            act_o = ACT_BRANCH;
        end else if (hold_i) begin
            act_o = ACT_HOLD;
        end else begin
            act_o = ACT_INC;
        end
    end

endmodule

// File: rtl/fas_addr_next.sv
module fas_addr_next
    import fas_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned NARROW_W = 26,
    parameter int unsigned STEP     = 4
) (
    input  fas_act_e            act_i,
    input  logic [ADDR_W-1:0]   cur_i,
    input  logic [ADDR_W-1:0]   target_i,
    input  logic                wide_mode_i,
    output logic [ADDR_W-1:0]   nxt_o,
    output logic                seq_o
);

    localparam logic [ADDR_W:0] STEP_EXT = (ADDR_W + 1)'(STEP);

    logic [ADDR_W-1:0] fetch_mask;
    logic [ADDR_W:0]   inc_full;
    logic [ADDR_W-1:0] inc_masked;

    generate
        if (NARROW_W < ADDR_W) begin : g_narrow
            localparam logic [ADDR_W-1:0] NARROW_MASK =
                {{(ADDR_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
            assign fetch_mask = wide_mode_i ? '1 : NARROW_MASK;
        end else begin : g_wide_only
            logic unused_mode;
            assign unused_mode = wide_mode_i;
            assign fetch_mask  = '1;
        end
    endgenerate

    // The carry bit is kept so that a step across the top is not sequential.
    assign inc_full   = {1'b0, cur_i} + STEP_EXT;
    assign inc_masked = inc_full[ADDR_W-1:0] & fetch_mask;

    always_comb begin
        unique case (act_i)
            ACT_DUMMY,
            ACT_INC:     nxt_o = inc_masked;
            ACT_RESTART: nxt_o = '0;
            ACT_BRANCH:  nxt_o = target_i & fetch_mask;
            ACT_HOLD:    nxt_o = cur_i;
            default:     nxt_o = inc_masked;
        endcase
    end

    assign seq_o = (nxt_o == cur_i) || ({1'b0, nxt_o} == inc_full);

endmodule

// File: rtl/fetch_addr_seq.sv
module fetch_addr_seq
    import fas_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned NARROW_W = 26,
    parameter int unsigned STEP     = 4
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wait_n_i,
    input  logic              wide_mode_i,
    input  logic              branch_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              hold_i,
    input  logic              write_next_i,
    input  logic              user_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rw_o,
    output logic              trans_o,
    output logic              seq_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rw;
        logic              trans;
        logic              in_reset;
    } cyc_t;

    cyc_t              st_d;
    cyc_t              st_q;
    fas_act_e          act;
    logic [ADDR_W-1:0] addr_nxt;

    fas_action_sel u_sel (
        .rst_n_i    (rst_n_i),
        .in_reset_i (st_q.in_reset),
        .branch_i   (branch_i),
        .hold_i     (hold_i),
        .act_o      (act)
    );

    fas_addr_next #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W),
        .STEP     (STEP)
    ) u_next (
        .act_i       (act),
        .cur_i       (st_q.addr),
        .target_i    (target_i),
        .wide_mode_i (wide_mode_i),
        .nxt_o       (addr_nxt),
        .seq_o       (seq_o)
    );

    always_comb begin
        st_d = st_q;
        if (wait_n_i) begin
            st_d.addr     = addr_nxt;
            st_d.in_reset = !rst_n_i;
            if (act == ACT_DUMMY) begin
                st_d.rw    = 1'b0;
                st_d.trans = 1'b1;
            end else begin
                st_d.rw    = write_next_i;
                st_d.trans = !user_i;
            end
        end
    end

    // The reset is functional: dummy fetches continue while it is low.
    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign addr_o  = st_q.addr;
    assign rw_o    = st_q.rw;
    assign trans_o = st_q.trans;

    AST_RESTART_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wait_n_i && st_q.in_reset |=> addr_o == '0); // R3

    AST_STALL_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !wait_n_i |=> $stable(addr_o) && $stable(rw_o) && $stable(trans_o)); // R4

    AST_SEQ_IS_NEAR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wait_n_i && seq_o |=>
            (addr_o == $past(addr_o)) || (addr_o == $past(addr_o) + ADDR_W'(STEP))); // R5

    AST_NOSEQ_MOVES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wait_n_i && !seq_o |=> addr_o != $past(addr_o)); // R5

    AST_WRITE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wait_n_i |=> rw_o == $past(write_next_i)); // R6

    AST_BRANCH_WIDE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wait_n_i && branch_i && wide_mode_i && !st_q.in_reset |=> addr_o == $past(target_i)); // R9

    generate
        if (NARROW_W < ADDR_W) begin : g_narrow_chk
            AST_NARROW_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
                wait_n_i && !wide_mode_i |=> addr_o[ADDR_W-1:NARROW_W] == '0); // R8
        end
    endgenerate

endmodule

// File: tb/fetch_addr_seq_tb.sv
module fetch_addr_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, wait_n, wide, branch, hold, wr_next, user;
    logic [31:0] target;
    logic [31:0] addr;
    logic        rw, trans, seq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_addr = '0;
    logic        exp_inrst = 1'b1;
    bit          known = 1'b0;

    always #2 clk = ~clk;

    fetch_addr_seq dut_i (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .wait_n_i     (wait_n),
        .wide_mode_i  (wide),
        .branch_i     (branch),
        .target_i     (target),
        .hold_i       (hold),
        .write_next_i (wr_next),
        .user_i       (user),
        .addr_o       (addr),
        .rw_o         (rw),
        .trans_o      (trans),
        .seq_o        (seq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: inputs driven just after an edge, lookahead sampled
    // mid-cycle, registered outputs sampled just after the following edge.
    task automatic cyc(input logic r, input logic w, input logic m, input logic b,
                       input logic h, input logic wn, input logic u,
                       input logic [31:0] t, input string tag);
        logic [31:0] mask, nx;
        logic        exp_seq, exp_rw, exp_tr;
        string       atag;
        rst_n = r; wait_n = w; wide = m; branch = b; hold = h;
        wr_next = wn; user = u; target = t;
        mask = m ? 32'hFFFF_FFFF : 32'h03FF_FFFF;
        if (!r)             nx = (exp_addr + 32'd4) & mask;
        else if (exp_inrst) nx = 32'd0;
        else if (b)         nx = t & mask;
        else if (h)         nx = exp_addr;
        else                nx = (exp_addr + 32'd4) & mask;
        exp_seq = (nx == exp_addr) || ({1'b0, nx} == {1'b0, exp_addr} + 33'd4);
        #1;
        if (known) check(seq === exp_seq, "R5 seq", {31'd0, seq}, {31'd0, exp_seq});
        @(posedge clk); #1;
        atag = w ? tag : "R4 stall";
        if (w) begin
            exp_addr  = nx;
            exp_inrst = !r;
            if (exp_inrst == 1'b0 && nx == 32'd0 && !known) known = 1'b1;
            exp_rw = r ? wn : 1'b0;
            exp_tr = r ? !u : 1'b1;
            if (!r) begin
                check(rw === 1'b0, "R1 dummy read", {31'd0, rw}, 32'd0);
                check(trans === 1'b1, "R1 dummy trans", {31'd0, trans}, 32'd1);
            end else begin
                check(rw === exp_rw, "R6 rw", {31'd0, rw}, {31'd0, exp_rw});
                check(trans === exp_tr, "R7 trans", {31'd0, trans}, {31'd0, exp_tr});
            end
        end
        if (known) check(addr === exp_addr, atag, addr, exp_addr);
    endtask

    initial begin
        rst_n = 0; wait_n = 1; wide = 1; branch = 0; hold = 0;
        wr_next = 0; user = 0; target = '0;
        @(posedge clk); #1;
        // Initial reset: dummy fetches, then restart at zero.
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 0, 1, 1, 0, "R1");
        cyc(1, 1, 1, 0, 0, 0, 0, 0, "R3 restart");
        check(addr === 32'd0, "R3 reset state", addr, 32'd0);
        // Plain increment with varying attributes.
        for (int i = 0; i < 8; i++) cyc(1, 1, 1, 0, 0, i[0], i[1], 0, "R9 inc");
        cyc(1, 1, 1, 0, 1, 0, 0, 0, "R9 hold");
        cyc(1, 1, 1, 1, 0, 1, 0, 32'h0000_0100, "R9 branch far");
        cyc(1, 1, 1, 1, 0, 0, 1, 32'h0000_0104, "R9 branch next");
        cyc(1, 1, 1, 1, 0, 0, 1, 32'h0000_0104, "R9 branch same");
        cyc(1, 1, 1, 1, 1, 0, 0, 32'h0000_0200, "R9 branch beats hold");
        // Consecutive stalls; other inputs and reset toggled meanwhile.
        cyc(1, 0, 1, 0, 0, 1, 1, 0, "R4");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R4");
        cyc(1, 0, 1, 0, 0, 1, 0, 0, "R4");
        cyc(1, 1, 1, 0, 0, 0, 0, 0, "R4 release");
        // Dummy-fetch wrap at the top of the 32-bit space, then restart.
        cyc(1, 1, 1, 1, 0, 0, 0, 32'hFFFF_FFF4, "R9");
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 0, 1, 1, 0, "R2 wrap32");
        cyc(1, 1, 1, 0, 0, 0, 0, 0, "R3 restart after wrap");
        // Single-cycle reset pulse.
        cyc(1, 1, 1, 1, 0, 0, 0, 32'h0000_8000, "R9");
        cyc(0, 1, 1, 0, 0, 0, 0, 0, "R1 short pulse");
        cyc(1, 1, 1, 0, 0, 0, 0, 0, "R3 short pulse");
        // 26-bit space: masked target, increment wrap, dummy wrap.
        cyc(1, 1, 0, 1, 0, 0, 0, 32'hFFFF_FFF8, "R8 masked target");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, "R8 inc");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, "R8 inc wrap");
        cyc(1, 1, 0, 1, 0, 0, 0, 32'h03FF_FFF8, "R8");
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0, "R2 wrap26");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, "R3");
        // Sweep over mixed inputs in both address modes.
        for (int i = 0; i < 400; i++) begin
            logic r, w, m, b, h;
            logic [31:0] t;
            r = !((i % 29) == 27 || (i % 29) == 28);
            w = (i % 6) != 5;
            m = (i / 50) % 2 == 0;
            b = (i % 7) == 3 || (i % 11) == 4;
            h = (i % 5) == 1;
            t = (i % 2 == 1) ? exp_addr + 32'd4 : 32'hFFFF_FF00 + 32'(i * 4);
            if (i % 9 == 0) t = exp_addr;
            cyc(r, w, m, b, h, i[0] ^ i[2], i[1], t, "R9 sweep");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule